// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic core of a simple integer datapath. Each cycle it takes a 4-bit operation code, two operands (the second already through an external shifter), the shifter's carry-out, and a marker that the shift was a left shift by zero. From these it forms a result and a write-enable for that result, with no register on the way. It also keeps a registered negative/zero/carry/overflow flag set, which loads on a rising clock edge when the set-flags control is high.

Logical operations combine the operands bit by bit. They take carry from the shifter, or keep it when the shift had zero distance, and they leave overflow alone. Arithmetic operations run on one adder. Subtraction is addition of the inverted operand with carry-in of one, and reverse forms swap the adder inputs. Four compare and test codes update the flags without asking for a result write. The operand width is a parameter, and other parameters pick the carry-chain form and the zero-detect form.

Top module: `dp_alu`

## Requirements
- R1: Logical codes give opa AND opb for 0000, opa XOR opb for 0001, opa OR opb for 1100, and opa AND NOT opb for 1110.
- R2: Code 1101 outputs opb and code 1111 outputs NOT opb. Neither depends on opa.
- R3: Code 0100 outputs opa+opb, 0010 outputs opa-opb, and 0011 outputs opb-opa, all modulo 2^DATA_W.
- R4: Code 0101 outputs opa+opb+C, 0110 outputs opa-opb+C-1, and 0111 outputs opb-opa+C-1, where C is the registered carry flag.
- R5: Codes 1000, 1001, 1010 and 1011 give the same result as 0000, 0001, 0010 and 0100 and hold the write-enable low. All other codes drive it high.
- R6: On an edge with set-flags high, N loads result bit DATA_W-1 and Z loads 1 exactly when the result is all zeros.
- R7: On an edge with set-flags high and an arithmetic code, C loads the carry-out of the addition. For a subtraction it is 1 when no borrow occurs.
- R8: On an edge with set-flags high and an arithmetic code, V loads 1 exactly when the two's-complement result is outside the signed range.
- R9: On an edge with set-flags high and a logical code, V keeps its value. C loads the shifter carry input, unless the zero-distance marker is high, in which case C keeps its value.
- R10: On an edge with set-flags low, all four flags keep their values.
- R11: An active-high synchronous reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 4 | Operation code |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand, after shifting |
| shc_i | input | 1 | Carry-out of the external shifter |
| shz_i | input | 1 | High when the shift was a left shift by zero |
| setf_i | input | 1 | Load the flags on this edge |
| res_o | output | DATA_W | Combinational result |
| wr_o | output | 1 | Result write-enable |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The carry flag is both an input to the combinational result and a register loaded in the same cycle. A carry-using code therefore reads the old C while the next C is being formed. The bench sets C to a known 0 or 1 with a move whose shifter carry is forced, then applies a carry-using or logical code with set-flags on or off. The combinational result is judged against the old carry before the edge, and all four flags are judged after it against an integer model of the same step.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
      OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
      OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
      OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   // arithmetic group: 0010..0111 and 1010, 1011
   function automatic logic op_is_arith(input logic [3:0] op);
      return (!op[3] && (op[2] || op[1])) || (op[3:2] == 2'b10 && op[1]);
   endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         4'b0000, 4'b1000: y = a & b;
         4'b0001, 4'b1001: y = a ^ b;
         4'b1100:          y = a | b;
         4'b1101:          y = b;
         4'b1110:          y = a & ~b;
         4'b1111:          y = ~b;
         default:          y = '0;
      endcase
   end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith #(
   parameter int DATA_W      = 32,
   parameter bit RIPPLE_CHAIN = 1'b0
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic              swap, invert;
   logic              carry_in;
   logic [DATA_W-1:0] x, y;

   always_comb begin
      swap   = !op[3] && (op[1:0] == 2'b11);
      invert = op[1] && (op != 4'b1011);
      unique case (op)
         4'b0100, 4'b1011:          carry_in = 1'b0;
         4'b0010, 4'b0011, 4'b1010: carry_in = 1'b1;
         default:                   carry_in = cin;
      endcase
      x = swap ? b : a;
      y = swap ? a : b;
      if (invert) y = ~y;
   end

   if (RIPPLE_CHAIN) begin : g_ripple
      logic [DATA_W:0] cc;
      assign cc[0] = carry_in;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]  = x[i] ^ y[i] ^ cc[i];
         assign cc[i+1] = (x[i] & y[i]) | (cc[i] & (x[i] ^ y[i]));
      end
      assign cout = cc[DATA_W];
   end else begin : g_wide
      assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, carry_in};
   end

   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
   import dp_alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ZDET_SLICE = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              setf,
   input  logic              arith,
   input  logic [DATA_W-1:0] res,
   input  logic              add_c,
   input  logic              add_v,
   input  logic              sh_c,
   input  logic              sh_zero,
   output alu_flags_t        q
);
   localparam int NSLICE = (ZDET_SLICE > 0) ? DATA_W / ZDET_SLICE : 1;

   logic       is_zero;
   alu_flags_t nxt;

   if (ZDET_SLICE == 0) begin : g_flat_z
      assign is_zero = ~|res;
   end else begin : g_slice_z
      logic [NSLICE-1:0] any;
      for (genvar s = 0; s < NSLICE; s++) begin : g_s
         assign any[s] = |res[s*ZDET_SLICE +: ZDET_SLICE];
      end
      assign is_zero = ~|any;
   end

   always_comb begin
      nxt.n = res[DATA_W-1];
      nxt.z = is_zero;
      if (arith) begin
         nxt.c = add_c;
         nxt.v = add_v;
      end else begin
         nxt.c = sh_zero ? q.c : sh_c;
         nxt.v = q.v;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (setf) q <= nxt;
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_CHAIN = 1'b0,
   parameter int ZDET_SLICE   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic              shc_i,
   input  logic              shz_i,
   input  logic              setf_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              flag_v_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dp_alu: DATA_W must be at least 2");
   end
   if (ZDET_SLICE < 0 || (ZDET_SLICE > 0 && DATA_W % ZDET_SLICE != 0)) begin : g_bad_slice
      $error("dp_alu: ZDET_SLICE must be 0 or divide DATA_W");
   end

   logic              arith;
   logic [DATA_W-1:0] log_y, add_y;
   logic              add_c, add_v;
   alu_flags_t        fl;

   assign arith = op_is_arith(op_i);

   dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op_i), .a(opa_i), .b(opb_i), .y(log_y)
   );

   dp_alu_arith #(.DATA_W(DATA_W), .RIPPLE_CHAIN(RIPPLE_CHAIN)) u_arith (
      .op(op_i), .a(opa_i), .b(opb_i), .cin(fl.c),
      .sum(add_y), .cout(add_c), .ovf(add_v)
   );

   assign res_o = arith ? add_y : log_y;
   assign wr_o  = (op_i[3:2] != 2'b10);

   dp_alu_flags #(.DATA_W(DATA_W), .ZDET_SLICE(ZDET_SLICE)) u_flags (
      .clk(clk), .rst(rst), .setf(setf_i), .arith(arith), .res(res_o),
      .add_c(add_c), .add_v(add_v), .sh_c(shc_i), .sh_zero(shz_i), .q(fl)
   );

   assign flag_n_o = fl.n;
   assign flag_z_o = fl.z;
   assign flag_c_o = fl.c;
   assign flag_v_o = fl.v;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] opa_i,
   input logic [DATA_W-1:0] opb_i,
   input logic              shc_i,
   input logic              shz_i,
   input logic              setf_i,
   input logic [DATA_W-1:0] res_o,
   input logic              wr_o,
   input logic              flag_n_o,
   input logic              flag_z_o,
   input logic              flag_c_o,
   input logic              flag_v_o
);
   logic lg;
   assign lg = !op_is_arith(op_i);

   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> {flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b0000);

   a_r6_neg_loads: assert property (@(posedge clk) disable iff (rst)
      setf_i |=> flag_n_o == $past(res_o[DATA_W-1]));

   a_r6_zero_loads: assert property (@(posedge clk) disable iff (rst)
      setf_i |=> flag_z_o == ($past(res_o) == '0));

   a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
      !setf_i |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));

   a_r9_v_kept: assert property (@(posedge clk) disable iff (rst)
      (setf_i && lg) |=> $stable(flag_v_o));

   a_r9_c_kept_zero_shift: assert property (@(posedge clk) disable iff (rst)
      (setf_i && lg && shz_i) |=> $stable(flag_c_o));

   a_r9_c_from_shifter: assert property (@(posedge clk) disable iff (rst)
      (setf_i && lg && !shz_i) |=> flag_c_o == $past(shc_i));

   a_r2_move_passes: assert property (@(posedge clk) disable iff (rst)
      (op_i == 4'b1101) |-> res_o == opb_i);

   a_r5_write_for_result_ops: assert property (@(posedge clk) disable iff (rst)
      (op_i[3:2] != 2'b10) |-> wr_o);
endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
   .shc_i(shc_i), .shz_i(shz_i), .setf_i(setf_i), .res_o(res_o), .wr_o(wr_o),
   .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
);

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
module dp_alu_test;
   localparam int W    = 8;
   localparam int MAXU = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [3:0]   op_i = '0;
   logic [W-1:0] opa_i = '0, opb_i = '0;
   logic         shc_i = 1'b0, shz_i = 1'b0, setf_i = 1'b0;
   logic [W-1:0] res_o;
   logic         wr_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the flag register
   logic mn = 0, mz = 0, mc = 0, mv = 0;

   always #4 clk = ~clk;

   dp_alu #(.DATA_W(W), .RIPPLE_CHAIN(1'b1), .ZDET_SLICE(4)) uut (
      .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
      .shc_i(shc_i), .shz_i(shz_i), .setf_i(setf_i), .res_o(res_o), .wr_o(wr_o),
      .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s op=%b a=%0d b=%0d: actual=%0d expected=%0d",
                  req, op_i, opa_i, opb_i, act, exp);
      end
   endtask

   function automatic string res_tag(input logic [3:0] op);
      case (op)
         4'b1101, 4'b1111:                   return "R2";
         4'b0100, 4'b0010, 4'b0011:          return "R3";
         4'b0101, 4'b0110, 4'b0111:          return "R4";
         4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R5";
         default:                            return "R1";
      endcase
   endfunction

   // one operation: result checked before the edge, flags after
   task automatic step(input logic [3:0] op, input int a, input int b,
                       input bit sf, input bit shc, input bit shz);
      int  u, s, sa, sb, ua, ub, ci;
      bit  ar, addf;
      logic [W-1:0] er;
      logic ec, ev;
      @(negedge clk);
      op_i = op; opa_i = a[W-1:0]; opb_i = b[W-1:0];
      setf_i = sf; shc_i = shc; shz_i = shz;
      ua = a & MAXU; ub = b & MAXU; ci = mc;
      sa = (ua > (MAXU >> 1)) ? ua - (MAXU + 1) : ua;
      sb = (ub > (MAXU >> 1)) ? ub - (MAXU + 1) : ub;
      ar = 1; addf = 0; u = 0; s = 0;
      case (op)
         4'b0010, 4'b1010: begin u = ua - ub;          s = sa - sb; end
         4'b0011:          begin u = ub - ua;          s = sb - sa; end
         4'b0100, 4'b1011: begin u = ua + ub;          s = sa + sb;          addf = 1; end
         4'b0101:          begin u = ua + ub + ci;     s = sa + sb + ci;     addf = 1; end
         4'b0110:          begin u = ua - ub + ci - 1; s = sa - sb + ci - 1; end
         4'b0111:          begin u = ub - ua + ci - 1; s = sb - sa + ci - 1; end
         default: ar = 0;
      endcase
      if (ar) begin
         er = u[W-1:0];
         ec = addf ? (u > MAXU) : (u >= 0);
         ev = (s > (MAXU >> 1)) || (s < -((MAXU >> 1) + 1));
      end else begin
         case (op)
            4'b0000, 4'b1000: er = opa_i & opb_i;
            4'b0001, 4'b1001: er = opa_i ^ opb_i;
            4'b1100:          er = opa_i | opb_i;
            4'b1101:          er = opb_i;
            4'b1110:          er = opa_i & ~opb_i;
            default:          er = ~opb_i;
         endcase
         ec = shz ? mc : shc;
         ev = mv;
      end
      #1;
      check(res_o == er, res_tag(op), res_o, er);
      check(wr_o == (op[3:2] != 2'b10), "R5 write-enable", wr_o, op[3:2] != 2'b10);
      @(posedge clk);
      if (sf) begin
         mn = er[W-1]; mz = (er == 0); mc = ec; mv = ev;
      end
      #1;
      check(flag_n_o == mn, sf ? "R6 N" : "R10 N", flag_n_o, mn);
      check(flag_z_o == mz, sf ? "R6 Z" : "R10 Z", flag_z_o, mz);
      check(flag_c_o == mc, !sf ? "R10 C" : (ar ? "R7 C" : "R9 C"), flag_c_o, mc);
      check(flag_v_o == mv, !sf ? "R10 V" : (ar ? "R8 V" : "R9 V"), flag_v_o, mv);
   endtask

   initial begin
      int cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b0000, "R11 reset",
            {flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 0);
      @(negedge clk);
      rst = 1'b0;
      for (int op = 0; op < 16; op++) begin
         for (int a = 0; a <= MAXU; a += 15) begin
            for (int b = 0; b <= MAXU; b += 15) begin
               for (int k = 0; k < 2; k++) begin
                  // force carry to k through a move
                  step(4'b1101, a, 0, 1'b1, k[0], 1'b0);
                  step(op[3:0], a, b, (cnt % 4) != 0, cnt[3], cnt[2]);
                  cnt++;
               end
            end
         end
      end
      // make the flags nonzero, then reset mid-run
      step(4'b0010, 0, 1, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      rst = 1'b1; setf_i = 1'b0;
      @(posedge clk); #1;
      mn = 0; mz = 0; mc = 0; mv = 0;
      check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b0000, "R11 mid-run reset",
            {flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 0);
      @(negedge clk);
      rst = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R11 watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule